// File: doc/BRIEF.md
# SPI NOR flash command target

This block is a synthesizable SPI slave that looks like a small NOR flash to a host controller. It is meant as a test target inside a chip or an FPGA. The SCLK, chip-select and MOSI pins are sampled by the system clock, with a configurable synchronizer depth. The first byte of every chip-select frame is decoded as an opcode. Any address bytes that follow are collected. The block then streams identification or array bytes back on MISO, or programs and erases an on-chip byte array whose size is set by parameters.

State carried across frames is kept to three items: a write-enable latch, a 3-byte or 4-byte address mode, and an armed flag for the two-step reset. Program data is ANDed into the array byte by byte as it arrives. Erase operations and all latch and mode updates take effect in the cycle in which the synchronized chip select is seen to rise. No status polling is needed. The array has `2**ADDR_W` bytes. It is split into sectors of `2**SECT_W` bytes and pages of `2**PAGE_W` bytes.

Top module: `spi_nor_target`

## Requirements
- R1: After opcode 0x9F, the next three bytes on MISO are 0x20, 0xBA and 0x19, in that order. Any byte after those three reads 0x00.
- R2: Opcode 0x03 takes an address. It then returns the array byte at that address, and at each following address, for as long as chip select stays low. The address wraps from the last array byte to byte 0.
- R3: Only a completed 0x06 frame sets the write-enable latch. Page program (0x02), sector erase (0xD8) and bulk erase (0xC7) leave the array unchanged while the latch is clear.
- R4: The latch is cleared when any 0x02, 0xD8 or 0xC7 frame ends. A second program needs a new 0x06.
- R5: Addresses are sent most significant byte first. Out of reset they are 3 bytes long. After a completed 0xB7 frame they are 4 bytes long.
- R6: A 0x99 frame that directly follows a 0x66 frame clears the latch and returns the block to 3-byte addresses. A 0x99 frame without a 0x66 frame just before it changes nothing, and neither does a 0x99 frame that follows a frame other than 0x66.
- R7: Sector erase sets every byte of the sector that holds the address (`2**SECT_W` bytes, 512 by default) to 0xFF. Bytes outside that sector are unchanged, including the page just below it.
- R8: Bulk erase sets every byte of the array to 0xFF.
- R9: Page program writes (old AND new) to each byte. The byte address advances within the current 256-byte page and wraps to the page start without changing the page.
- R10: Address bits at and above bit ADDR_W are ignored. An address with those bits set reaches the same byte as the same address with them clear.
- R11: SPI mode 0 is used: MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge. MISO is 0 while chip select is high and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select that frames one command |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The assertions assume a well-behaved SPI host. SCLK idles low. Chip select changes only while SCLK is low. Each SCLK half period lasts longer than the synchronizer and edge-detect latency plus one cycle for the array lookup. Frames are separated by enough idle clocks for the frame-end actions to settle. The bench holds every SCLK level for eight system clocks. It drives chip select only between bytes with SCLK low, and it waits several half periods after each frame. The byte strobe, the latch and the address pointer therefore move only in the orderings the properties describe.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

   localparam logic [7:0] OP_ID    = 8'h9F;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_BULK  = 8'hC7;
   localparam logic [7:0] OP_SECT  = 8'hD8;
   localparam logic [7:0] OP_ADDR4 = 8'hB7;
   localparam logic [7:0] OP_RSTEN = 8'h66;
   localparam logic [7:0] OP_RST   = 8'h99;

   typedef enum logic [2:0] {
      PH_OPC,
      PH_ADDR,
      PH_READ,
      PH_PROG,
      PH_ID,
      PH_SKIP
   } phase_e;

   // identification sequence, zero once exhausted
   function automatic logic [7:0] id_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    id_byte = 8'h20;
         2'd1:    id_byte = 8'hBA;
         2'd2:    id_byte = 8'h19;
         default: id_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/spi_nor_sync.sv
module spi_nor_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("spi_nor_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end

      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/spi_nor_shifter.sv
module spi_nor_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_s,
   input  logic       cs_n_s,
   input  logic       mosi_s,
   input  logic [7:0] tx_byte,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       frame_end,
   output logic       miso
);

   logic       sclk_d;
   logic       cs_d;
   logic [2:0] bitcnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;
   logic       miso_r;
   logic       rise;
   logic       fall;

   assign rise      =  sclk_s & ~sclk_d & ~cs_n_s;
   assign fall      = ~sclk_s &  sclk_d & ~cs_n_s;
   assign frame_end =  cs_n_s & ~cs_d;
   assign miso      =  miso_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt    <= '0;
         rx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
         tx_sh     <= '0;
         miso_r    <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (cs_n_s) begin
            bitcnt <= '0;
            tx_sh  <= '0;
            miso_r <= 1'b0;
         end else begin
            if (rise) begin
               rx_sh  <= {rx_sh[5:0], mosi_s};
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  byte_done <= 1'b1;
                  rx_byte   <= {rx_sh, mosi_s};
               end
            end
            if (fall) begin
               if (bitcnt == 3'd0) begin
                  miso_r <= tx_byte[7];
                  tx_sh  <= {tx_byte[6:0], 1'b0};
               end else begin
                  miso_r <= tx_sh[7];
                  tx_sh  <= {tx_sh[6:0], 1'b0};
               end
            end
         end
      end
   end

   // R11: output idles low whenever the synchronized select is high
   p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !miso);

   // R2: one strobe per received byte, never two in a row
   p_byte_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

endmodule

// File: rtl/spi_nor_array.sv
module spi_nor_array #(
   parameter int ADDR_W = 11,
   parameter int SECT_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   output logic [7:0]               rd_data,
   input  logic                     wr_en,
   input  logic [7:0]               wr_data,
   input  logic                     bulk_erase,
   input  logic                     sect_erase,
   input  logic [ADDR_W-SECT_W-1:0] sect_idx
);

   localparam int NSECT  = 1 << (ADDR_W - SECT_W);
   localparam int SDEPTH = 1 << SECT_W;
   localparam int SIDX_W = ADDR_W - SECT_W;

   logic [7:0]        sect_rd [NSECT];
   logic [SECT_W-1:0] offs;
   logic [SIDX_W-1:0] hit_sect;

   assign offs     = addr[SECT_W-1:0];
   assign hit_sect = addr[ADDR_W-1:SECT_W];

   for (genvar s = 0; s < NSECT; s++) begin : g_sector
      logic [7:0] smem [SDEPTH];
      logic       wipe;
      logic       hit;

      assign wipe = bulk_erase | (sect_erase & (sect_idx == SIDX_W'(s)));
      assign hit  = wr_en & (hit_sect == SIDX_W'(s));

      always_ff @(posedge clk) begin
         if (wipe) begin
            for (int i = 0; i < SDEPTH; i++) smem[i] <= 8'hFF;
         end else if (hit) begin
            smem[offs] <= smem[offs] & wr_data;
         end
      end

      assign sect_rd[s] = smem[offs];
   end

   assign rd_data = sect_rd[hit_sect];

   // R7: erase and program strobes never coincide
   p_one_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bulk_erase, sect_erase, wr_en}));

endmodule

// File: rtl/spi_nor_ctrl.sv
module spi_nor_ctrl
   import spi_nor_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 8,
   parameter int SECT_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     byte_done,
   input  logic [7:0]               rx_byte,
   input  logic                     frame_end,
   input  logic [7:0]               rd_data,
   output logic [7:0]               tx_byte,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     wr_en,
   output logic [7:0]               wr_data,
   output logic                     bulk_erase,
   output logic                     sect_erase,
   output logic [ADDR_W-SECT_W-1:0] sect_idx
);

   phase_e            phase;
   logic [7:0]        opcode;
   logic              op_valid;
   logic [1:0]        abytes;
   logic [ADDR_W-9:0] addr_sh;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] new_addr;
   logic              addr_done;
   logic [1:0]        id_idx;
   logic              wel;
   logic              addr4;
   logic              rst_armed;
   logic              last_abyte;

   assign new_addr   = {addr_sh, rx_byte};
   assign last_abyte = (abytes == (addr4 ? 2'd3 : 2'd2));

   assign mem_addr   = ptr;
   assign sect_idx   = ptr[ADDR_W-1:SECT_W];
   assign wr_data    = rx_byte;
   assign wr_en      = byte_done & (phase == PH_PROG) & wel;
   assign bulk_erase = frame_end & op_valid & (opcode == OP_BULK) & wel;
   assign sect_erase = frame_end & op_valid & (opcode == OP_SECT) & wel & addr_done;

   always_comb begin
      case (phase)
         PH_READ: tx_byte = rd_data;
         PH_ID:   tx_byte = id_byte(id_idx);
         default: tx_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OPC;
         opcode    <= '0;
         op_valid  <= 1'b0;
         abytes    <= '0;
         addr_sh   <= '0;
         ptr       <= '0;
         addr_done <= 1'b0;
         id_idx    <= '0;
         wel       <= 1'b0;
         addr4     <= 1'b0;
         rst_armed <= 1'b0;
      end else if (frame_end) begin
         phase     <= PH_OPC;
         op_valid  <= 1'b0;
         abytes    <= '0;
         addr_done <= 1'b0;
         if (op_valid) begin
            rst_armed <= (opcode == OP_RSTEN);
            case (opcode)
               OP_WREN:  wel   <= 1'b1;
               OP_ADDR4: addr4 <= 1'b1;
               OP_RST: begin
                  if (rst_armed) begin
                     wel   <= 1'b0;
                     addr4 <= 1'b0;
                  end
               end
               OP_PROG, OP_SECT, OP_BULK: wel <= 1'b0;
               default: ;
            endcase
         end
      end else if (byte_done) begin
         case (phase)
            PH_OPC: begin
               opcode   <= rx_byte;
               op_valid <= 1'b1;
               id_idx   <= '0;
               case (rx_byte)
                  OP_READ, OP_PROG, OP_SECT: phase <= PH_ADDR;
                  OP_ID:                     phase <= PH_ID;
                  default:                   phase <= PH_SKIP;
               endcase
            end
            PH_ADDR: begin
               addr_sh <= new_addr[ADDR_W-9:0];
               abytes  <= abytes + 2'd1;
               if (last_abyte) begin
                  addr_done <= 1'b1;
                  ptr       <= new_addr;
                  if (opcode == OP_READ)      phase <= PH_READ;
                  else if (opcode == OP_PROG) phase <= PH_PROG;
                  else                        phase <= PH_SKIP;
               end
            end
            PH_READ: ptr <= ptr + 1'b1;
            PH_PROG: ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            PH_ID:   if (id_idx != 2'd3) id_idx <= id_idx + 2'd1;
            default: ;
         endcase
      end
   end

   // R3: the latch only rises at the end of a write-enable frame
   p_wel_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(frame_end && op_valid && (opcode == OP_WREN)));

   // R4: a program or erase frame leaves the latch clear
   p_wel_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && op_valid &&
       ((opcode == OP_PROG) || (opcode == OP_SECT) || (opcode == OP_BULK)))
      |=> !wel);

   // R5: 4-byte mode is entered only by its own opcode
   p_mode_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr4) |-> $past(frame_end && op_valid && (opcode == OP_ADDR4)));

   // R6: an armed reset clears both the latch and the address mode
   p_reset_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && op_valid && (opcode == OP_RST) && rst_armed)
      |=> (!wel && !addr4));

   // R9: programming never leaves the current page
   p_page_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && (phase == PH_PROG) && !frame_end)
      |=> $stable(ptr[ADDR_W-1:PAGE_W]));

endmodule

// File: rtl/spi_nor_target.sv
module spi_nor_target #(
   parameter int ADDR_W      = 11,
   parameter int SECT_W      = 9,
   parameter int PAGE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic miso
);

   localparam int SIDX_W = ADDR_W - SECT_W;

   if (ADDR_W > 24) begin : g_bad_addr
      $error("spi_nor_target: ADDR_W must fit a 3-byte address");
   end
   if (SECT_W >= ADDR_W) begin : g_bad_sect
      $error("spi_nor_target: the array needs at least two sectors");
   end
   if ((PAGE_W != 8) || (PAGE_W > SECT_W)) begin : g_bad_page
      $error("spi_nor_target: pages are 256 bytes and fit in a sector");
   end

   logic              sclk_s;
   logic              cs_n_s;
   logic              mosi_s;
   logic              byte_done;
   logic [7:0]        rx_byte;
   logic              frame_end;
   logic [7:0]        tx_byte;
   logic [7:0]        rd_data;
   logic [ADDR_W-1:0] mem_addr;
   logic              wr_en;
   logic [7:0]        wr_data;
   logic              bulk_erase;
   logic              sect_erase;
   logic [SIDX_W-1:0] sect_idx;

   spi_nor_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, cs_n, mosi}),
      .q     ({sclk_s, cs_n_s, mosi_s})
   );

   spi_nor_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .cs_n_s    (cs_n_s),
      .mosi_s    (mosi_s),
      .tx_byte   (tx_byte),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .frame_end (frame_end),
      .miso      (miso)
   );

   spi_nor_ctrl #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .SECT_W (SECT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .frame_end  (frame_end),
      .rd_data    (rd_data),
      .tx_byte    (tx_byte),
      .mem_addr   (mem_addr),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .bulk_erase (bulk_erase),
      .sect_erase (sect_erase),
      .sect_idx   (sect_idx)
   );

   spi_nor_array #(
      .ADDR_W (ADDR_W),
      .SECT_W (SECT_W)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (mem_addr),
      .rd_data    (rd_data),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .bulk_erase (bulk_erase),
      .sect_erase (sect_erase),
      .sect_idx   (sect_idx)
   );

endmodule

// File: tb/spi_nor_target_test.sv
module spi_nor_target_test;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic sclk  = 1'b0;
   logic cs_n  = 1'b1;
   logic mosi  = 1'b0;
   wire  miso;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] rbuf [32];
   logic [7:0] wbuf [32];

   always #2 clk = ~clk;

   spi_nor_target uut (
      .clk   (clk),
      .rst_n (rst_n),
      .sclk  (sclk),
      .cs_n  (cs_n),
      .mosi  (mosi),
      .miso  (miso)
   );

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         half();
         rx[i] = miso;
         sclk = 1'b1;
         half();
         sclk = 1'b0;
      end
   endtask

   task automatic cs_lo();
      cs_n = 1'b0;
      half();
   endtask

   task automatic cs_hi();
      half();
      cs_n = 1'b1;
      repeat (4) half();
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] d;
      cs_lo();
      xfer(op, d);
      cs_hi();
   endtask

   task automatic send_addr(input logic [31:0] a, input bit four);
      logic [7:0] d;
      if (four) xfer(a[31:24], d);
      xfer(a[23:16], d);
      xfer(a[15:8], d);
      xfer(a[7:0], d);
   endtask

   task automatic rd(input logic [31:0] a, input int n, input bit four);
      logic [7:0] d;
      cs_lo();
      xfer(8'h03, d);
      send_addr(a, four);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, d);
         rbuf[i] = d;
      end
      cs_hi();
   endtask

   task automatic pp(input logic [31:0] a, input int n, input bit four);
      logic [7:0] d;
      cs_lo();
      xfer(8'h02, d);
      send_addr(a, four);
      for (int i = 0; i < n; i++) xfer(wbuf[i], d);
      cs_hi();
   endtask

   task automatic se(input logic [31:0] a, input bit four);
      logic [7:0] d;
      cs_lo();
      xfer(8'hD8, d);
      send_addr(a, four);
      cs_hi();
   endtask

   task automatic t_reset();
      check("R11", "miso after reset", {31'd0, miso}, 32'd0);
   endtask

   task automatic t_id();
      logic [7:0] d;
      cs_lo();
      xfer(8'h9F, d);
      xfer(8'h00, d); check("R1", "id byte 0", {24'd0, d}, 32'h20);
      xfer(8'h00, d); check("R1", "id byte 1", {24'd0, d}, 32'hBA);
      xfer(8'h00, d); check("R1", "id byte 2", {24'd0, d}, 32'h19);
      xfer(8'h00, d); check("R1", "id byte 3", {24'd0, d}, 32'h00);
      cs_hi();
      check("R11", "miso idle after frame", {31'd0, miso}, 32'd0);
   endtask

   task automatic t_bulk();
      cmd(8'h06);
      cmd(8'hC7);
      rd(32'h000000, 4, 1'b0);
      for (int i = 0; i < 4; i++) check("R8", "low bytes erased", {24'd0, rbuf[i]}, 32'hFF);
      rd(32'h0007FC, 4, 1'b0);
      for (int i = 0; i < 4; i++) check("R8", "top bytes erased", {24'd0, rbuf[i]}, 32'hFF);
   endtask

   task automatic t_prog_no_wel();
      wbuf[0] = 8'h00;
      wbuf[1] = 8'h00;
      pp(32'h000010, 2, 1'b0);
      rd(32'h000010, 2, 1'b0);
      check("R3", "program without latch", {rbuf[0], rbuf[1]}, 32'hFFFF);
   endtask

   task automatic t_prog_wrap();
      cmd(8'h06);
      for (int i = 0; i < 12; i++) wbuf[i] = 8'hA0 + 8'(i);
      pp(32'h0001FA, 12, 1'b0);
      rd(32'h0001FA, 6, 1'b0);
      for (int i = 0; i < 6; i++)
         check("R9", "page tail", {24'd0, rbuf[i]}, 32'hA0 + i);
      rd(32'h000100, 6, 1'b0);
      for (int i = 0; i < 6; i++)
         check("R9", "wrapped to page start", {24'd0, rbuf[i]}, 32'hA6 + i);
      rd(32'h000200, 1, 1'b0);
      check("R9", "next page untouched", {24'd0, rbuf[0]}, 32'hFF);
      wbuf[0] = 8'h00;
      pp(32'h000300, 1, 1'b0);
      rd(32'h000300, 1, 1'b0);
      check("R4", "latch cleared by program", {24'd0, rbuf[0]}, 32'hFF);
   endtask

   task automatic t_and();
      cmd(8'h06);
      wbuf[0] = 8'h3C;
      pp(32'h0001FA, 1, 1'b0);
      rd(32'h0001FA, 2, 1'b0);
      check("R9", "AND into programmed byte", {24'd0, rbuf[0]}, 32'h20);
      check("R9", "neighbour unchanged", {24'd0, rbuf[1]}, 32'hA1);
   endtask

   task automatic t_read_wrap();
      cmd(8'h06);
      wbuf[0] = 8'h5A;
      pp(32'h0007FF, 1, 1'b0);
      cmd(8'h06);
      wbuf[0] = 8'h11;
      pp(32'h000000, 1, 1'b0);
      rd(32'h0007FE, 3, 1'b0);
      check("R2", "stream byte 0", {24'd0, rbuf[0]}, 32'hFF);
      check("R2", "stream byte 1", {24'd0, rbuf[1]}, 32'h5A);
      check("R2", "stream wraps to 0", {24'd0, rbuf[2]}, 32'h11);
      rd(32'h0807FF, 1, 1'b0);
      check("R10", "upper address bits ignored", {24'd0, rbuf[0]}, 32'h5A);
   endtask

   task automatic t_sector();
      cmd(8'h06);
      wbuf[0] = 8'h55;
      wbuf[1] = 8'h66;
      pp(32'h000200, 2, 1'b0);
      rd(32'h000200, 2, 1'b0);
      check("R9", "sector 1 programmed", {rbuf[0], rbuf[1]}, 32'h5566);
      cmd(8'h06);
      se(32'h0002A0, 1'b0);
      rd(32'h000200, 2, 1'b0);
      check("R7", "sector erased", {rbuf[0], rbuf[1]}, 32'hFFFF);
      rd(32'h0001FA, 2, 1'b0);
      check("R7", "page below sector kept", {rbuf[0], rbuf[1]}, 32'h20A1);
      rd(32'h000000, 1, 1'b0);
      check("R7", "sector 0 kept", {24'd0, rbuf[0]}, 32'h11);
      cmd(8'h06);
      wbuf[0] = 8'h42;
      pp(32'h000210, 1, 1'b0);
      se(32'h000200, 1'b0);
      rd(32'h000210, 1, 1'b0);
      check("R3", "erase without latch", {24'd0, rbuf[0]}, 32'h42);
   endtask

   task automatic t_modes();
      rd(32'h0001FB, 1, 1'b0);
      check("R5", "3-byte address", {24'd0, rbuf[0]}, 32'hA1);
      cmd(8'hB7);
      rd(32'h000001FB, 1, 1'b1);
      check("R5", "4-byte address", {24'd0, rbuf[0]}, 32'hA1);
      cmd(8'h99);
      rd(32'h000001FB, 1, 1'b1);
      check("R6", "lone reset ignored", {24'd0, rbuf[0]}, 32'hA1);
      cmd(8'h06);
      cmd(8'h66);
      cmd(8'h99);
      rd(32'h0001FB, 1, 1'b0);
      check("R6", "reset back to 3-byte", {24'd0, rbuf[0]}, 32'hA1);
      wbuf[0] = 8'h00;
      pp(32'h000220, 1, 1'b0);
      rd(32'h000220, 1, 1'b0);
      check("R6", "reset cleared latch", {24'd0, rbuf[0]}, 32'hFF);
      cmd(8'hB7);
      cmd(8'h66);
      cmd(8'h06);
      cmd(8'h99);
      wbuf[0] = 8'h77;
      pp(32'h00000230, 1, 1'b1);
      rd(32'h00000230, 1, 1'b1);
      check("R6", "interrupted reset ignored", {24'd0, rbuf[0]}, 32'h77);
   endtask

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_id();
      t_bulk();
      t_prog_no_wel();
      t_prog_wrap();
      t_and();
      t_read_wrap();
      t_sector();
      t_modes();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule